// File: doc/BRIEF.md
# SMM RAM Window Decoder

This block decides, one access at a time, whether a memory address falls into the system-management RAM window and, if so, which DRAM address it lands on and whether the access may proceed. A configuration byte written through a simple write strobe selects one of four window modes and sets an open flag. The open flag lets code running outside system-management mode reach the window. Code running inside system-management mode may always reach it.

A small state machine holds the programmed window mode. Its states are `WIN_OFF`, `WIN_LOWDRAM`, `WIN_HIGHBIOS` and `WIN_RELOC`. Reset enters `WIN_OFF`. On every configuration write there is one transition, from any state to the state that bits 5:4 of the written byte encode: 0 → `WIN_OFF`, 1 → `WIN_LOWDRAM`, 2 → `WIN_HIGHBIOS`, 3 → `WIN_RELOC`. Without a write the state does not change.

Each access is decoded against the current state. The result is registered and appears one clock later. `WIN_HIGHBIOS` is only honoured while the shadow control value is all zeros. `WIN_RELOC` moves a low host window up onto the DRAM area at A0000h.

Top module: `smm_window_decoder`

## Requirements
- R1: After reset the state is `WIN_OFF` and the open flag is clear. Every response is then a miss with permit low, and `rsp_valid` is low until the first access.
- R2: A write with `cfg_we` high loads bits 5:4 of `cfg_wdata` as the mode and bit 3 as the open flag. Other bits have no effect. An access in the same cycle as the write is decoded with the old setting. An access in any later cycle uses the new setting.
- R3: In mode 0 no address hits. `rsp_addr` then equals the access address and `rsp_permit` is low.
- R4: In mode 1, addresses A0000h–BFFFFh hit and map to the same DRAM address.
- R5: In mode 2, addresses E0000h–EFFFFh hit and map to the same address, but only while `shadow_ctrl` is zero. With any bit of `shadow_ctrl` set, no address hits.
- R6: In mode 3, host addresses 30000h–4FFFFh hit and map to A0000h plus the offset from 30000h. Host addresses A0000h–BFFFFh do not hit in this mode.
- R7: `rsp_permit` is high exactly when the access hits and either `acc_smm` or the open flag is set.
- R8: Responses arrive one cycle after the access. A cycle with `acc_valid` low gives a response with `rsp_valid`, `rsp_hit`, `rsp_permit` low and `rsp_addr` zero.
- R9: The window edges are exact at byte granularity. The first and last byte of a window hit, and the byte just below and just above it miss. A miss returns the access address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte: mode in bits 5:4, open flag in bit 3 |
| shadow_ctrl | input | 8 | Shadow control value; mode 2 needs it to be zero |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 20 | Host address of the access |
| acc_smm | input | 1 | The CPU is in system-management mode |
| rsp_valid | output | 1 | Registered response for last cycle's access |
| rsp_hit | output | 1 | The access fell inside the active window |
| rsp_addr | output | 20 | Remapped DRAM address, or the access address on a miss |
| rsp_permit | output | 1 | The access hits and is allowed |

## Verification
The hardest case to reach from the ports is an access in the very cycle a new mode is written. It must still be decoded with the old mode. The stimulus writes mode 1 while presenting A0000h and expects a miss, then presents the same address in the next cycle and expects a hit. A second hard case is mode 2 losing its window while the mode field is unchanged. The stimulus keeps mode 2 programmed and only flips `shadow_ctrl` from zero to nonzero between two accesses to the same address. A cycle-by-cycle reference model in the bench tracks the configuration and is compared on every clock.

// File: rtl/smm_win_pkg.sv
package smm_win_pkg;

    typedef enum logic [1:0] {
        WIN_OFF      = 2'd0,
        WIN_LOWDRAM  = 2'd1,
        WIN_HIGHBIOS = 2'd2,
        WIN_RELOC    = 2'd3
    } win_state_e;

    localparam int CFG_W    = 8;
    localparam int MODE_LSB = 4;
    localparam int OPEN_BIT = 3;
    localparam int NUM_WIN  = 3;

    // comparator slots: 0 = low DRAM, 1 = high BIOS, 2 = relocated host window
    function automatic int unsigned win_host_base(int idx);
        case (idx)
            0:       return 32'h000A_0000;
            1:       return 32'h000E_0000;
            default: return 32'h0003_0000;
        endcase
    endfunction

    function automatic int unsigned win_dram_base(int idx);
        case (idx)
            1:       return 32'h000E_0000;
            default: return 32'h000A_0000;
        endcase
    endfunction

    function automatic int unsigned win_span(int idx);
        case (idx)
            1:       return 32'h0001_0000;
            default: return 32'h0002_0000;
        endcase
    endfunction

endpackage

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
    import smm_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output win_state_e       cur_state,
    output logic             cfg_open
);

    win_state_e nxt_state;
    logic       nxt_open;
    logic       unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[CFG_W-1:MODE_LSB+2], cfg_wdata[OPEN_BIT-1:0]};

    always_comb begin
        nxt_state = cur_state;
        nxt_open  = cfg_open;
        if (cfg_we) begin
            nxt_open = cfg_wdata[OPEN_BIT];
            unique case (cfg_wdata[MODE_LSB +: 2])
                2'd0: nxt_state = WIN_OFF;
                2'd1: nxt_state = WIN_LOWDRAM;
                2'd2: nxt_state = WIN_HIGHBIOS;
                2'd3: nxt_state = WIN_RELOC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_state <= WIN_OFF;
            cfg_open  <= 1'b0;
        end else begin
            cur_state <= nxt_state;
            cfg_open  <= nxt_open;
        end
    end

    // R2
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cur_state == win_state_e'($past(cfg_wdata[MODE_LSB +: 2]))))
        else $error("mode field not loaded");

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cur_state) && $stable(cfg_open))
        else $error("mode changed without a write");

endmodule

// File: rtl/smm_range_cmp.sv
module smm_range_cmp #(
    parameter int          ADDR_W    = 20,
    parameter int unsigned HOST_BASE = 32'h000A_0000,
    parameter int unsigned DRAM_BASE = 32'h000A_0000,
    parameter int unsigned SPAN      = 32'h0002_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [ADDR_W-1:0] phys
);

    localparam logic [ADDR_W-1:0] LO  = ADDR_W'(HOST_BASE);
    localparam logic [ADDR_W-1:0] HI  = ADDR_W'(HOST_BASE + SPAN - 1);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(DRAM_BASE - HOST_BASE);

    always_comb begin
        in_win = (addr >= LO) && (addr <= HI);
        phys   = addr + OFS;
    end

endmodule

// File: rtl/smm_resp_reg.sv
module smm_resp_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic              d_hit,
    input  logic              d_permit,
    input  logic [ADDR_W-1:0] d_addr,
    output logic              q_valid,
    output logic              q_hit,
    output logic              q_permit,
    output logic [ADDR_W-1:0] q_addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_hit    <= 1'b0;
            q_permit <= 1'b0;
            q_addr   <= '0;
        end else begin
            q_valid  <= d_valid;
            q_hit    <= d_hit;
            q_permit <= d_permit;
            q_addr   <= d_addr;
        end
    end

endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder
    import smm_win_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int SHADOW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [SHADOW_W-1:0] shadow_ctrl,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_smm,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic                rsp_permit
);

    localparam logic [ADDR_W-1:0] DRAM_LO = ADDR_W'(win_dram_base(0));
    localparam logic [ADDR_W-1:0] DRAM_HI = ADDR_W'(win_dram_base(0) + win_span(0) - 1);

    win_state_e              cur_state;
    logic                    cfg_open;
    logic [NUM_WIN-1:0]      win_hit;
    logic [ADDR_W-1:0]       win_phys [NUM_WIN];
    logic                    sel_hit;
    logic [ADDR_W-1:0]       sel_phys;
    logic                    d_hit;
    logic                    d_permit;
    logic [ADDR_W-1:0]       d_addr;

    smm_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cur_state (cur_state),
        .cfg_open  (cfg_open)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        smm_range_cmp #(
            .ADDR_W    (ADDR_W),
            .HOST_BASE (win_host_base(g)),
            .DRAM_BASE (win_dram_base(g)),
            .SPAN      (win_span(g))
        ) u_cmp (
            .addr   (acc_addr),
            .in_win (win_hit[g]),
            .phys   (win_phys[g])
        );
    end

    always_comb begin
        sel_hit  = 1'b0;
        sel_phys = acc_addr;
        unique case (cur_state)
            WIN_OFF: begin
                sel_hit = 1'b0;
            end
            WIN_LOWDRAM: begin
                sel_hit  = win_hit[0];
                sel_phys = win_phys[0];
            end
            WIN_HIGHBIOS: begin
                sel_hit  = win_hit[1] && (shadow_ctrl == '0);
                sel_phys = win_phys[1];
            end
            WIN_RELOC: begin
                sel_hit  = win_hit[2];
                sel_phys = win_phys[2];
            end
        endcase
    end

    always_comb begin
        d_hit    = acc_valid && sel_hit;
        d_permit = d_hit && (acc_smm || cfg_open);
        if (!acc_valid)
            d_addr = '0;
        else if (sel_hit)
            d_addr = sel_phys;
        else
            d_addr = acc_addr;
    end

    smm_resp_reg #(.ADDR_W(ADDR_W)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .d_valid  (acc_valid),
        .d_hit    (d_hit),
        .d_permit (d_permit),
        .d_addr   (d_addr),
        .q_valid  (rsp_valid),
        .q_hit    (rsp_hit),
        .q_permit (rsp_permit),
        .q_addr   (rsp_addr)
    );

    // R3
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == WIN_OFF && acc_valid) |=> !rsp_hit && (rsp_addr == $past(acc_addr)))
        else $error("hit while windows off");

    // R7
    permit_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_permit |-> rsp_hit)
        else $error("permit without hit");

    // R7
    closed_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_smm && !cfg_open) |=> !rsp_permit)
        else $error("permit outside SMM with window closed");

    // R5
    shadow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == WIN_HIGHBIOS && shadow_ctrl != '0 && acc_valid) |=> !rsp_hit)
        else $error("high window hit while shadowing on");

    // R6
    reloc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == WIN_RELOC && acc_valid) |=>
            (!rsp_hit || (rsp_addr >= DRAM_LO && rsp_addr <= DRAM_HI)))
        else $error("relocated address outside DRAM window");

    // R8
    resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid)
        else $error("response missing");

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid && !rsp_hit && !rsp_permit && (rsp_addr == '0))
        else $error("response on idle cycle");

endmodule

// File: tb/smm_window_decoder_bench.sv
`timescale 1ns/1ps
module smm_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  shadow_ctrl = '0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_smm = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_permit;
    logic [19:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    int m_mode = 0;
    bit m_open = 1'b0;

    always #2 clk = ~clk;

    smm_window_decoder u_smm_window_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .shadow_ctrl (shadow_ctrl),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .acc_smm     (acc_smm),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_addr    (rsp_addr),
        .rsp_permit  (rsp_permit)
    );

    task automatic cmp(input string tag, input logic [22:0] act, input logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual v/h/p/addr=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive, let the edge pass, compare with the model, then advance the model
    task automatic step(input string tag, input logic we, input logic [7:0] wd,
                        input logic v, input logic [19:0] a, input logic smm,
                        input logic [7:0] sh);
        int unsigned ua;
        bit e_hit;
        bit e_perm;
        logic [19:0] e_addr;
        cfg_we = we; cfg_wdata = wd; acc_valid = v; acc_addr = a;
        acc_smm = smm; shadow_ctrl = sh;
        @(posedge clk);
        @(negedge clk);
        ua = a;
        e_hit = 1'b0;
        e_addr = a;
        if (m_mode == 1 && ua >= 'hA0000 && ua <= 'hBFFFF) e_hit = 1'b1;
        if (m_mode == 2 && sh == 8'h00 && ua >= 'hE0000 && ua <= 'hEFFFF) e_hit = 1'b1;
        if (m_mode == 3 && ua >= 'h30000 && ua <= 'h4FFFF) begin
            e_hit = 1'b1;
            e_addr = 20'(ua - 'h30000 + 'hA0000);
        end
        e_perm = e_hit && (smm || m_open);
        if (!v) begin
            e_hit = 1'b0; e_perm = 1'b0; e_addr = '0;
        end
        cmp(tag, {rsp_valid, rsp_hit, rsp_permit, rsp_addr}, {v, e_hit, e_perm, e_addr});
        if (we) begin
            m_mode = int'(wd[5:4]);
            m_open = wd[3];
        end
        cfg_we = 1'b0; acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 reset", {rsp_valid, rsp_hit, rsp_permit, rsp_addr}, 23'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after reset idle", {rsp_valid, rsp_hit, rsp_permit, rsp_addr}, 23'h0);
        step("R1 no window", 0, 8'h00, 1, 20'hA0000, 1, 8'h00);
        // R3 mode 0 misses everywhere
        step("R3 low", 0, 8'h00, 1, 20'h30000, 1, 8'h00);
        step("R3 high", 0, 8'h00, 1, 20'hE4000, 1, 8'h00);
        // R2 write together with access: old mode applies
        step("R2 same cycle", 1, 8'h10, 1, 20'hA0000, 1, 8'h00);
        step("R2 next cycle R4", 0, 8'h00, 1, 20'hA0000, 1, 8'h00);
        step("R4 R7 closed outside smm", 0, 8'h00, 1, 20'hB1234, 0, 8'h00);
        // R9 edges of the low window
        step("R9 below", 0, 8'h00, 1, 20'h9FFFF, 1, 8'h00);
        step("R9 last", 0, 8'h00, 1, 20'hBFFFF, 1, 8'h00);
        step("R9 above", 0, 8'h00, 1, 20'hC0000, 1, 8'h00);
        // R8 idle cycle
        step("R8 idle", 0, 8'h00, 0, 20'hA0000, 1, 8'h00);
        // R5 high window
        step("R5 load", 1, 8'h20, 0, 20'h0, 0, 8'h00);
        step("R5 hit", 0, 8'h00, 1, 20'hE0000, 1, 8'h00);
        step("R5 last", 0, 8'h00, 1, 20'hEFFFF, 1, 8'h00);
        step("R5 R9 above", 0, 8'h00, 1, 20'hF0000, 1, 8'h00);
        step("R5 R9 below", 0, 8'h00, 1, 20'hDFFFF, 1, 8'h00);
        step("R5 shadow on", 0, 8'h00, 1, 20'hE8000, 1, 8'h10);
        step("R5 shadow one bit", 0, 8'h00, 1, 20'hE8000, 1, 8'h01);
        step("R5 shadow off again", 0, 8'h00, 1, 20'hE8000, 1, 8'h00);
        step("R5 low miss", 0, 8'h00, 1, 20'hA0000, 1, 8'h00);
        // R6 relocation with open flag, extra bits set to show they are ignored (R2)
        step("R6 R2 load open", 1, 8'hF8, 0, 20'h0, 0, 8'h00);
        step("R6 R7 open base", 0, 8'h00, 1, 20'h30000, 0, 8'h00);
        step("R6 last", 0, 8'h00, 1, 20'h4FFFF, 0, 8'h00);
        step("R6 mid smm", 0, 8'h00, 1, 20'h41234, 1, 8'h00);
        step("R6 R9 below", 0, 8'h00, 1, 20'h2FFFF, 1, 8'h00);
        step("R6 R9 above", 0, 8'h00, 1, 20'h50000, 1, 8'h00);
        step("R6 dram alias miss", 0, 8'h00, 1, 20'hA0000, 1, 8'h00);
        step("R6 shadow ignored", 0, 8'h00, 1, 20'h30010, 0, 8'hFF);
        // R2 back to mode 0 with open flag set and low bits set
        step("R2 off load", 1, 8'hCF, 1, 20'h30000, 0, 8'h00);
        step("R2 R3 off", 0, 8'h00, 1, 20'h30000, 1, 8'h00);
        step("R3 R8 idle", 0, 8'h00, 0, 20'h30000, 1, 8'h00);
        // R7 mode 1 with open flag
        step("R7 load open low", 1, 8'h18, 0, 20'h0, 0, 8'h00);
        step("R7 open outside smm", 0, 8'h00, 1, 20'hA8000, 0, 8'h00);
        step("R7 R4 smm", 0, 8'h00, 1, 20'hA8000, 1, 8'h00);
        step("R8 tail", 0, 8'h00, 0, 20'h0, 0, 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule